// File: doc/BRIEF.md
# Single-cycle 8-bit processor with soft and hard stop

This block is a small processor that completes one instruction in each clock cycle. A program counter addresses a 256-word instruction store, and each word is 21 bits wide. The fetched word is decoded the same cycle. Two 8-bit operands are chosen from an eight-entry register file, or from the immediate field for the second operand. An internal ALU combines them, and the result is written back on the next rising clock edge. The contents of the registers and the program counter are the only visible outputs.

A control unit derives the register write enable and the immediate select from the 4-bit opcode. It also manages two stop conditions. A soft stop suppresses every later register write, but the program counter keeps counting and wrapping. A hard stop freezes the program counter for good. A synchronous `resetall` clears the registers, the program counter and the soft stop, but the hard stop survives it. A clocked load port fills the instruction store before a run.

Top module: `cpu8_core`

## Requirements
- R1: The instruction word is decoded combinationally at address `pc`. The fields are opcode [20:17], destination [16:14], first source [13:11], second source [10:8] and unsigned immediate [7:0].
- R2: After `resetall` is released, `pc` starts at 0, advances by one each cycle, and wraps from 255 to 0.
- R3: The opcodes write the destination register with these results: 1 inverts the first source; 2 ANDs; 3 XORs; 4 ORs; 7 copies the first source; 11 shifts left by one and fills with 0; 12 shifts right by one and fills with 0; 13 gives 1 when the two sources are equal and 0 otherwise.
- R4: Opcodes 0 (no-op), 14 (soft stop) and 15 (hard stop) write no register.
- R5: Opcodes 8 (load immediate), 9 (add immediate) and 10 (subtract immediate) take the immediate as the second operand and ignore the second source field. All other opcodes use the register named by the second source field.
- R6: Opcodes 5/9 add and 6/10 subtract the second operand from the first, modulo 256. The carry out is discarded.
- R7: After opcode 14 executes, `pc` keeps advancing, but no register changes until `resetall`.
- R8: Opcode 15 still takes effect while the soft stop is active.
- R9: When opcode 15 executes, `pc` stays at that instruction's address, and no instruction writes a register from then on. A later `resetall` clears the registers but does not move `pc` or lift the hard stop.
- R10: `resetall` sets all eight registers to 0, sets `pc` to 0 (unless hard-stopped) and clears the soft stop.
- R11: Register 0 is an ordinary writable register.
- R12: When `prog_we` is high on a rising edge, `prog_data` is stored at `prog_addr` in the instruction store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| resetall | input | 1 | Synchronous reset of registers, pc and soft stop |
| prog_we | input | 1 | Instruction store write strobe |
| prog_addr | input | 8 | Instruction store write address |
| prog_data | input | 21 | Instruction word to store |
| pc | output | 8 | Program counter |
| gpr | output | 64 | Registers x0..x7 packed, x0 in bits [7:0] |

## Verification
One program runs every computing opcode on an operand pair chosen so that the add overflows and the subtract borrows. It shows any wrong opcode decode or a carry that is not dropped. The same program checks that the second source field is ignored in immediate forms, and that a no-op with non-zero fields leaves the registers unchanged. The program then soft-stops with a pending write behind it, and the bench lets `pc` wrap. This separates "counter stops" from "writes stop". A second program soft-stops, then hard-stops, and applies `resetall` afterwards. This tells apart the flag that reset clears from the flag that it leaves in place.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int OPW = 4;
  localparam int CLA_GRP = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 4'd0,  OP_NOT  = 4'd1,  OP_AND  = 4'd2,  OP_XOR  = 4'd3,
    OP_OR   = 4'd4,  OP_ADD  = 4'd5,  OP_SUB  = 4'd6,  OP_MOV  = 4'd7,
    OP_MOVI = 4'd8,  OP_ADDI = 4'd9,  OP_SUBI = 4'd10, OP_SLL  = 4'd11,
    OP_SRL  = 4'd12, OP_CMP  = 4'd13, OP_HLT  = 4'd14, OP_HCF  = 4'd15
  } op_e;
endpackage

// File: rtl/cpu8_imem.sv
module cpu8_imem #(
  parameter int AW = 8,
  parameter int IW = 21
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int DW = 8,
  parameter int NREG = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [$clog2(NREG)-1:0]   wa,
  input  logic [DW-1:0]             wd,
  output logic [NREG-1:0][DW-1:0]   q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q[i] <= '0;
      else if (we && wa == i) q[i] <= wd;
    end
  end

  // R4: without a write enable nothing in the file moves
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
  // R11: entry 0 takes data like any other
  a_r11_x0_write: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> q[0] == $past(wd));
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  // carry into bit base+len, formed only from g/p of the group and its carry-in
  function automatic logic grp_carry(input logic [DW-1:0] g, input logic [DW-1:0] p,
                                     input logic cin, input int base, input int len);
    logic acc;
    logic chain;
    acc = cin;
    for (int j = 0; j < len; j++) acc = acc & p[base+j];
    for (int j = 0; j < len; j++) begin
      chain = g[base+j];
      for (int k = j + 1; k < len; k++) chain = chain & p[base+k];
      acc = acc | chain;
    end
    return acc;
  endfunction

  function automatic logic [DW-1:0] cla_sum(input logic [DW-1:0] x, input logic [DW-1:0] z,
                                            input logic cin);
    logic [DW-1:0] g, p, c;
    logic gin;
    g = x & z;
    p = x ^ z;
    gin = cin;
    c = '0;
    for (int base = 0; base < DW; base += CLA_GRP) begin
      for (int k = 0; k < CLA_GRP; k++)
        if (base + k < DW) c[base+k] = grp_carry(g, p, gin, base, k);
      gin = grp_carry(g, p, gin, base, (DW - base < CLA_GRP) ? DW - base : CLA_GRP);
    end
    return p ^ c;
  endfunction

  always_comb begin
    unique case (op)
      OP_NOT:          y = ~a;
      OP_AND:          y = a & b;
      OP_XOR:          y = a ^ b;
      OP_OR:           y = a | b;
      OP_ADD, OP_ADDI: y = cla_sum(a, b, 1'b0);
      OP_SUB, OP_SUBI: y = cla_sum(a, ~b, 1'b1);
      OP_MOV:          y = a;
      OP_MOVI:         y = b;
      OP_SLL:          y = {a[DW-2:0], 1'b0};
      OP_SRL:          y = {1'b0, a[DW-1:1]};
      OP_CMP:          y = DW'(a == b);
      default:         y = '0;
    endcase
  end
endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_e  op,
  output logic wen,
  output logic b_imm,
  output logic pc_hold,
  output logic halted,
  output logic fired
);
  logic halted_q;
  logic fire_q = 1'b0;
  logic live, hlt_hit, hcf_hit;

  assign live    = !halted_q && !fire_q;
  assign hlt_hit = live && op == OP_HLT;
  assign hcf_hit = !fire_q && op == OP_HCF;
  assign wen     = live && !(op inside {OP_NOP, OP_HLT, OP_HCF});
  assign b_imm   = op inside {OP_MOVI, OP_ADDI, OP_SUBI};
  assign pc_hold = fire_q || hcf_hit;
  assign halted  = halted_q;
  assign fired   = fire_q;

  always_ff @(posedge clk) begin
    if (rst) halted_q <= 1'b0;
    else if (hlt_hit) halted_q <= 1'b1;
  end

  // hard stop survives resetall
  always_ff @(posedge clk) begin
    if (!rst && hcf_hit) fire_q <= 1'b1;
  end

  // R8: hard stop is honoured during a soft stop
  a_r8_fire_over_halt: assert property (@(posedge clk) disable iff (rst)
    (halted_q && op == OP_HCF) |=> fire_q);
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 8
) (
  input  logic                         clk,
  input  logic                         resetall,
  input  logic                         prog_we,
  input  logic [AW-1:0]                prog_addr,
  input  logic [OPW+3*$clog2(NREG)+DW-1:0] prog_data,
  output logic [AW-1:0]                pc,
  output logic [NREG-1:0][DW-1:0]      gpr
);
  localparam int RW     = $clog2(NREG);
  localparam int IW     = OPW + 3 * RW + DW;
  localparam int RS2_LO = DW;
  localparam int RS1_LO = RS2_LO + RW;
  localparam int RD_LO  = RS1_LO + RW;
  localparam int OP_LO  = RD_LO + RW;

  function automatic logic [AW-1:0] pc_next(input logic [AW-1:0] cur, input logic hold);
    return hold ? cur : cur + AW'(1);
  endfunction

  logic [IW-1:0] ins;
  op_e           op;
  logic [RW-1:0] rd, rs1, rs2;
  logic [DW-1:0] imm, a_val, b_val, res;
  logic          wen, b_imm, pc_hold, halted, fired;

  cpu8_imem #(.AW(AW), .IW(IW)) u_imem (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr(pc), .rdata(ins));

  assign op  = op_e'(ins[OP_LO +: OPW]);
  assign rd  = ins[RD_LO +: RW];
  assign rs1 = ins[RS1_LO +: RW];
  assign rs2 = ins[RS2_LO +: RW];
  assign imm = ins[DW-1:0];

  cpu8_ctrl u_ctrl (
    .clk(clk), .rst(resetall), .op(op), .wen(wen), .b_imm(b_imm),
    .pc_hold(pc_hold), .halted(halted), .fired(fired));

  assign a_val = gpr[rs1];
  assign b_val = b_imm ? imm : gpr[rs2];

  cpu8_alu #(.DW(DW)) u_alu (.op(op), .a(a_val), .b(b_val), .y(res));

  cpu8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(resetall), .we(wen), .wa(rd), .wd(res), .q(gpr));

  always_ff @(posedge clk) begin
    if (resetall) pc <= fired ? pc : '0;
    else pc <= pc_next(pc, pc_hold);
  end

  // R2: counter steps by one while not hard-stopped
  a_r2_pc_step: assert property (@(posedge clk) disable iff (resetall)
    (!fired && op != OP_HCF) |=> pc == $past(pc) + AW'(1));
  // R9: once hard-stopped the counter never moves
  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (resetall)
    fired |=> $stable(pc));
  // R7: soft stop blocks every register change except via hard stop
  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (resetall)
    (halted && op != OP_HCF) |=> $stable(gpr));
endmodule

// File: tb/test_cpu8_core.sv
module test_cpu8_core;
  logic        clk = 1'b0;
  logic        resetall = 1'b1;
  logic        prog_we = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [20:0] prog_data = '0;
  logic [7:0]  pc;
  logic [7:0][7:0] gpr;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";
  bit cmp_on = 1'b0;

  int m_mem [256];
  int m_r [8];
  int m_pc = 0;
  bit m_halt = 1'b0;
  bit m_fire = 1'b0;

  always #10 clk = ~clk;

  cpu8_core i_cpu8_core (
    .clk(clk), .resetall(resetall), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .pc(pc), .gpr(gpr));

  function automatic logic [20:0] enc(int op, int rd, int s1, int s2, int imm);
    return {4'(op), 3'(rd), 3'(s1), 3'(s2), 8'(imm)};
  endfunction

  function automatic int ref_alu(int op, int a, int b);
    case (op)
      1: return (~a) & 255;
      2: return a & b;
      3: return a ^ b;
      4: return a | b;
      5, 9: return (a + b) % 256;
      6, 10: return (a - b + 256) % 256;
      7: return a;
      8: return b;
      11: return (a * 2) % 256;
      12: return a / 2;
      13: return (a == b) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, updated on each edge from bench inputs only
  always @(posedge clk) begin
    int w, op, rd, s1, s2, imm, bv;
    w = m_mem[m_pc];
    op = (w >> 17) & 15; rd = (w >> 14) & 7; s1 = (w >> 11) & 7;
    s2 = (w >> 8) & 7; imm = w & 255;
    if (resetall) begin
      foreach (m_r[i]) m_r[i] = 0;
      m_halt = 1'b0;
      if (!m_fire) m_pc = 0;
    end else if (!m_fire) begin
      if (op == 15) m_fire = 1'b1;
      else begin
        if (!m_halt) begin
          if (op == 14) m_halt = 1'b1;
          else if (op != 0) begin
            bv = (op >= 8 && op <= 10) ? imm : m_r[s2];
            m_r[rd] = ref_alu(op, m_r[s1], bv);
          end
        end
        m_pc = (m_pc + 1) % 256;
      end
    end
    if (prog_we) m_mem[prog_addr] = prog_data;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(cur_req, pc, m_pc);
      for (int i = 0; i < 8; i++) check(cur_req, gpr[i], m_r[i]);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [20:0] prog [32]);
    for (int a = 0; a < 256; a++) begin
      prog_we = 1'b1; prog_addr = 8'(a);
      prog_data = (a < 32) ? prog[a] : 21'd0;
      step(1);
    end
    prog_we = 1'b0;
  endtask

  initial begin
    logic [20:0] pa [32];
    logic [20:0] pb [32];
    foreach (m_mem[i]) m_mem[i] = 0;
    foreach (pa[i]) begin pa[i] = '0; pb[i] = '0; end
    pa[0]  = enc(8, 0, 0, 0, 8'h5A);
    pa[1]  = enc(8, 1, 0, 0, 8'hC3);
    pa[2]  = enc(5, 2, 0, 1, 0);
    pa[3]  = enc(6, 3, 0, 1, 0);
    pa[4]  = enc(2, 4, 0, 1, 0);
    pa[5]  = enc(3, 5, 0, 1, 0);
    pa[6]  = enc(4, 6, 0, 1, 0);
    pa[7]  = enc(1, 7, 0, 0, 0);
    pa[8]  = enc(7, 4, 1, 0, 0);
    pa[9]  = enc(9, 5, 0, 1, 8'hFF);
    pa[10] = enc(10, 6, 0, 1, 8'h10);
    pa[11] = enc(11, 7, 1, 0, 0);
    pa[12] = enc(12, 3, 1, 0, 0);
    pa[13] = enc(13, 2, 0, 0, 0);
    pa[14] = enc(13, 1, 0, 1, 0);
    pa[15] = enc(0, 0, 1, 2, 8'h77);
    pa[16] = enc(14, 0, 0, 0, 0);
    pa[17] = enc(8, 0, 0, 0, 8'hFF);
    pb[0] = enc(8, 3, 0, 0, 7);
    pb[1] = enc(14, 0, 0, 0, 0);
    pb[2] = enc(8, 3, 0, 0, 9);
    pb[3] = enc(15, 0, 0, 0, 0);

    step(2);
    cmp_on = 1'b1;
    check("R10", pc, 0);
    check("R10", gpr[5], 0);
    cur_req = "R12";
    load(pa);
    resetall = 1'b0;
    cur_req = "R3";
    step(16);
    check("R11", gpr[0], 8'h5A);
    check("R6", gpr[2], 1);
    check("R3", gpr[7], 8'h86);
    check("R3", gpr[3], 8'h61);
    check("R3", gpr[1], 0);
    check("R5", gpr[5], 8'h59);
    check("R6", gpr[6], 8'h4A);
    check("R1", pc, 16);
    cur_req = "R7";
    step(1);
    step(300);
    check("R2", pc, 61);
    check("R7", gpr[0], 8'h5A);
    check("R4", gpr[4], 8'hC3);

    cur_req = "R10";
    resetall = 1'b1;
    step(2);
    check("R10", pc, 0);
    check("R10", gpr[0], 0);
    load(pb);
    resetall = 1'b0;
    cur_req = "R8";
    step(4);
    check("R7", gpr[3], 7);
    check("R8", pc, 3);
    cur_req = "R9";
    step(10);
    check("R9", pc, 3);
    resetall = 1'b1;
    step(3);
    check("R9", pc, 3);
    check("R10", gpr[3], 0);
    resetall = 1'b0;
    step(5);
    check("R9", pc, 3);
    check("R9", gpr[3], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule